// File: doc/BRIEF.md
# Synthesizer Divider Stages

This block holds the digital dividers that sit around a frequency synthesizer's oscillator. A programmable counter divides the incoming high-speed clock by a 9-bit value to make the feedback pulse for the phase comparison. A second stage divides the same clock by a power of two chosen by a 2-bit code, with equal high and low times. That divided clock drives two differential-style output pairs. Each pair has a true output and its inverse.

A 2-bit select chooses one of four internal nodes for a test pin. The settings come from configuration logic outside this block and are sampled on the block's own clock. A new value only takes effect at the end of the current period of the divider concerned. An active-high master reset holds both counters at their start point and forces the outputs to a fixed level.

Top module: `synth_divider_core`

## Requirements
- R1: The output divide code selects the division ratio: 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4 and 2'b11 by 8.
- R2: For every divide code the divided clock is high for exactly half of each output period.
- R3: For a feedback value M of 2 or more, the feedback output is high for one input cycle once every M input cycles. The bits of the value weigh 256 (bit 8) down to 1 (bit 0).
- R4: A feedback value of 0 or 1 passes the input clock straight to the feedback output.
- R5: While reset is high, both true outputs are low, both complement outputs are high and the feedback output is low. After release the counters start again from zero, so for divide by 4 the first high phase begins with the second input cycle.
- R6: The test select picks the test output: 2'b00 gives constant low, 2'b01 the serial data input, 2'b10 the feedback output and 2'b11 the divided clock.
- R7: Both output pairs carry the same divided clock, and each complement output is always the inverse of its true output.
- R8: A change of the divide code takes effect only after the current output period has completed.
- R9: A change of the feedback value takes effect only after the current feedback period has completed.
- R10: Switching into or out of divide by 1 gives a clean change of ratio, with full half-cycles on either side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-speed clock to be divided |
| rst | input | 1 | Master reset, active high, sampled synchronously |
| m_val | input | 9 | Feedback divide value |
| n_code | input | 2 | Output divide code |
| t_sel | input | 2 | Test output select |
| sdata_in | input | 1 | Serial data bit offered to the test output |
| fb_out | output | 1 | Feedback pulse |
| out0_p | output | 1 | Divided clock, pair 0 true |
| out0_n | output | 1 | Divided clock, pair 0 complement |
| out1_p | output | 1 | Divided clock, pair 1 true |
| out1_n | output | 1 | Divided clock, pair 1 complement |
| test_out | output | 1 | Selected test node |

## Verification
Each divide code is run over a 48-cycle window and sampled in both halves of every input cycle. The count of rising edges separates the four ratios, and the count of high samples confirms the even duty. Feedback values of 0, 1, 2, 3, 7, 10, 28, 48 and 300 are paired with different codes. Their pulse counts separate pass-through from real division and test the top bit's weight. Directed sequences change a setting mid-period and measure the run lengths that follow, which shows whether the change waited for the period boundary. Other sequences cross into and out of divide by 1, assert reset in the middle of a run, and step the test select through its sources.

// File: rtl/synth_divider_core.sv
module synth_divider_core #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input  logic           clk_in,
  input  logic           rst,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_code,
  input  logic [1:0]     t_sel,
  input  logic           sdata_in,
  output logic           fb_out,
  output logic           out0_p,
  output logic           out0_n,
  output logic           out1_p,
  output logic           out1_n,
  output logic           test_out
);
  localparam int CW = (1 << N_W) - 1;

  logic [N_W-1:0] n_act;
  logic [CW-1:0]  cnt;
  logic [CW:0]    odiv;
  logic           o_term, q_div, en1, tru;

  assign odiv   = {{CW{1'b0}}, 1'b1} << n_act;
  assign o_term = ({1'b0, cnt} == odiv - 1'b1);
  assign q_div  = (n_act != '0) && ({1'b0, cnt} >= (odiv >> 1));

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt   <= '0;
      n_act <= n_code;
    end else begin
      cnt <= o_term ? '0 : cnt + 1'b1;
      if (o_term) n_act <= n_code;
    end
  end

  always_ff @(negedge clk_in) en1 <= !rst && (n_act == '0);

  assign tru    = !rst && (en1 ? clk_in : q_div);
  assign out0_p = tru;
  assign out1_p = tru;
  assign out0_n = !tru;
  assign out1_n = !tru;

  logic [M_W-1:0] m_act, mc;
  logic           m_pass, m_term;

  assign m_pass = (m_act <= 1);
  assign m_term = m_pass || (mc == m_act - 1'b1);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      mc    <= '0;
      m_act <= m_val;
    end else begin
      mc <= m_term ? '0 : mc + 1'b1;
      if (m_term) m_act <= m_val;
    end
  end

  assign fb_out = !rst && (m_pass ? clk_in : (mc == '0));

  always_comb begin
    case (t_sel)
      2'b00:   test_out = 1'b0;
      2'b01:   test_out = sdata_in;
      2'b10:   test_out = fb_out;
      default: test_out = tru;
    endcase
  end

  // R1
  out_cnt_range_chk: assert property (@(posedge clk_in) disable iff (rst)
    {1'b0, cnt} < odiv);

  // R8
  n_switch_chk: assert property (@(posedge clk_in) disable iff (rst)
    (n_act != $past(n_act)) |-> $past(o_term));

  // R9
  m_switch_chk: assert property (@(posedge clk_in) disable iff (rst)
    (m_act != $past(m_act)) |-> $past(m_term));

  // R3
  fb_single_chk: assert property (@(posedge clk_in) disable iff (rst)
    (m_act > 1 && mc == '0) |=> (mc != '0));
endmodule

// File: tb/test_synth_divider_core.sv
module test_synth_divider_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] m_val = 9'd10;
  logic [1:0] n_code = 2'd0, t_sel = 2'd0;
  logic sdata_in = 1'b0;
  logic fb_out, out0_p, out0_n, out1_p, out1_n, test_out;

  synth_divider_core i_synth_divider_core (
    .clk_in(clk), .rst(rst), .m_val(m_val), .n_code(n_code), .t_sel(t_sel),
    .sdata_in(sdata_in), .fb_out(fb_out), .out0_p(out0_p), .out0_n(out0_n),
    .out1_p(out1_p), .out1_n(out1_n), .test_out(test_out));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int rises, highs, fbh, tst_h, tst_r, pair_bad;
  logic [95:0] wave;

  // {n_code, m_val, t_sel, expected rises, expected feedback highs}
  localparam logic [28:0] VEC [9] = '{
    {2'd0, 9'd10,  2'd0, 8'd48, 8'd4},
    {2'd1, 9'd28,  2'd2, 8'd24, 8'd1},
    {2'd2, 9'd3,   2'd3, 8'd12, 8'd16},
    {2'd3, 9'd7,   2'd2, 8'd6,  8'd6},
    {2'd0, 9'd0,   2'd3, 8'd48, 8'd48},
    {2'd1, 9'd1,   2'd2, 8'd24, 8'd48},
    {2'd3, 9'd2,   2'd3, 8'd6,  8'd24},
    {2'd2, 9'd300, 2'd2, 8'd12, 8'd0},
    {2'd1, 9'd48,  2'd0, 8'd24, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] n, input logic [8:0] m, input logic [1:0] t);
    @(posedge clk); #1;
    rst = 1'b1; n_code = n; m_val = m; t_sel = t;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic sample(input bit hph, inout logic p0, inout logic pt, input int idx);
    wave[idx] = out0_p;
    if (out0_p && !p0) rises++;
    if (out0_p) highs++;
    if (hph && fb_out) fbh++;
    if (hph && test_out) tst_h++;
    if (test_out && !pt) tst_r++;
    if (out1_p !== out0_p || out0_n !== ~out0_p || out1_n !== ~out0_p) pair_bad++;
    p0 = out0_p;
    pt = test_out;
  endtask

  task automatic run_window(input int ncyc);
    logic p0, pt;
    p0 = out0_p; pt = test_out;
    rises = 0; highs = 0; fbh = 0; tst_h = 0; tst_r = 0; pair_bad = 0; wave = '0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #2;
      sample(1'b1, p0, pt, 2*c);
      #4;
      sample(1'b0, p0, pt, 2*c+1);
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt_a, cnt_b, cnt_c;
    // R5 reset state with pass-through settings that would otherwise show the clock
    rst = 1'b1; n_code = 2'd0; m_val = 9'd0; t_sel = 2'd3;
    repeat (2) @(posedge clk);
    #2;
    chk(!out0_p && out0_n && !out1_p && out1_n && !fb_out, "R5 reset high phase",
        {out0_p, out0_n, out1_p, out1_n, fb_out}, 5'b01010);
    #4;
    chk(!out0_p && out0_n && !out1_p && out1_n && !fb_out, "R5 reset low phase",
        {out0_p, out0_n, out1_p, out1_n, fb_out}, 5'b01010);

    for (int v = 0; v < 9; v++) begin
      logic [28:0] e;
      e = VEC[v];
      do_reset(e[28:27], e[26:18], e[17:16]);
      run_window(48);
      chk(rises == int'(e[15:8]), "R1 rising edges", rises, e[15:8]);
      chk(highs == 48, "R2 duty high samples", highs, 48);
      chk(fbh == int'(e[7:0]), (e[26:18] <= 1) ? "R4 pass-through" : "R3 feedback pulses",
          fbh, e[7:0]);
      chk(pair_bad == 0, "R7 pair match", pair_bad, 0);
      case (e[17:16])
        2'd0: chk(tst_h == 0, "R6 test low", tst_h, 0);
        2'd2: chk(tst_h == int'(e[7:0]), "R6 test feedback", tst_h, e[7:0]);
        default: chk(tst_r == int'(e[15:8]), "R6 test divided clock", tst_r, e[15:8]);
      endcase
    end

    // R6 serial data source
    t_sel = 2'd1; sdata_in = 1'b1; #1;
    chk(test_out == 1'b1, "R6 test serial 1", test_out, 1);
    sdata_in = 1'b0; #1;
    chk(test_out == 1'b0, "R6 test serial 0", test_out, 0);

    // R8 divide-code change mid-period: /8 high phase completes, then /2
    do_reset(2'd3, 9'd10, 2'd0);
    cnt_a = 0;
    while (cnt_a < 40) begin
      @(posedge clk); #2;
      if (out0_p) break;
      cnt_a++;
    end
    n_code = 2'd1;
    cnt_a = 1;
    while (cnt_a < 40) begin @(posedge clk); #2; if (!out0_p) break; cnt_a++; end
    cnt_b = 1;
    while (cnt_b < 40) begin @(posedge clk); #2; if (out0_p) break; cnt_b++; end
    cnt_c = 1;
    while (cnt_c < 40) begin @(posedge clk); #2; if (!out0_p) break; cnt_c++; end
    chk(cnt_a == 4, "R8 old high phase kept", cnt_a, 4);
    chk(cnt_b == 1, "R8 new low phase", cnt_b, 1);
    chk(cnt_c == 1, "R8 new high phase", cnt_c, 1);

    // R9 feedback-value change mid-period
    do_reset(2'd1, 9'd10, 2'd0);
    cnt_a = 0;
    while (cnt_a < 40) begin @(posedge clk); #2; if (fb_out) break; cnt_a++; end
    m_val = 9'd3;
    cnt_a = 0;
    while (cnt_a < 40) begin @(posedge clk); #2; cnt_a++; if (fb_out) break; end
    cnt_b = 0;
    while (cnt_b < 40) begin @(posedge clk); #2; cnt_b++; if (fb_out) break; end
    chk(cnt_a == 10, "R9 old feedback gap", cnt_a, 10);
    chk(cnt_b == 3, "R9 new feedback gap", cnt_b, 3);

    // R10 into and out of divide by 1
    do_reset(2'd0, 9'd5, 2'd3);
    run_window(8);
    chk(rises == 8, "R10 divide by 1 before switch", rises, 8);
    n_code = 2'd2;
    run_window(4);
    run_window(48);
    chk(rises == 12 && highs == 48, "R10 after switch to /4", rises, 12);
    n_code = 2'd0;
    run_window(4);
    run_window(48);
    chk(rises == 48 && highs == 48, "R10 after switch to /1", rises, 48);

    // R5 reset in the middle of a run, then restart
    do_reset(2'd2, 9'd5, 2'd0);
    run_window(10);
    @(posedge clk); #1 rst = 1'b1;
    run_window(3);
    chk(highs == 0 && pair_bad == 0 && fbh == 0, "R5 outputs held in reset",
        highs + fbh + pair_bad, 0);
    @(posedge clk); #1 rst = 1'b0;
    run_window(4);
    chk(wave[7:0] == 8'h3C, "R5 restart pattern", wave[7:0], 8'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule